// File: doc/BRIEF.md
# Character Display Parallel Bus Engine

This block is the host side of an asynchronous parallel bus to a character display controller. The bus has a register-select line, a read/write line, an enable strobe and an 8-bit data bus. A client hands the engine one request: the register-select value, a direction and a byte. The engine then runs a single bus transaction. It places the select and direction lines ahead of the strobe, holds the strobe high for the minimum pulse and keeps everything stable after the falling edge. It also pads the transaction so that strobes keep the minimum spacing from rising edge to rising edge.

Every interval is a parameter in nanoseconds. Each one becomes a whole number of system clock cycles, rounded up. In narrow mode only the four upper data lines are used, and each byte takes two strobes with the high nibble first. Reads sample the bus just before the strobe falls. In narrow mode a read builds the byte from the two sampled nibbles in the same order. The data bus driver is released for the whole of a read.

Top module: `chrbus_engine`

## Requirements
- R1: After reset, and whenever no transaction is running, busy_o, done_o, bus_en_o and bus_d_oe_o are all 0.
- R2: A request is accepted on a clock edge where req_i is 1 and busy_o is 0. bus_rs_o then equals req_rs_i and bus_rw_o equals req_rd_i, and both hold until the next accepted request. The four combinations are: rs=0/rw=0 instruction write, rs=0/rw=1 status and address read, rs=1/rw=0 data write, rs=1/rw=1 data read.
- R3: Each strobe rises ceil(40 ns / clock period) cycles after its transaction slot starts (2 cycles at 50 MHz). bus_rs_o and bus_rw_o do not change while bus_en_o is high, nor on the cycle when it falls.
- R4: bus_en_o stays high for max(ceil(220 ns/T), ceil(120 ns/T), ceil(60 ns/T)) cycles, which is 11 at 50 MHz.
- R5: Each strobe slot lasts max(ceil(500 ns/T), setup+pulse+hold) cycles (25 at 50 MHz). Two strobes of one transaction rise exactly one slot apart.
- R6: In 8-bit mode (mode4_i=0 at acceptance), a write drives bus_d_o = the byte with bus_d_oe_o=1 for the whole transaction. bus_d_o does not change while the strobe is high.
- R7: In 4-bit mode (mode4_i=1 at acceptance), a write makes two strobes. The first carries byte[7:4] on bus_d_o[7:4] and the second carries byte[3:0] there. bus_d_o[3:0] is 0.
- R8: During a read, bus_d_oe_o is 0 for the whole transaction. In 8-bit mode rd_data_o equals bus_d_i as sampled in the last cycle with bus_en_o high.
- R9: In 4-bit mode a read makes two strobes. bus_d_i[7:4] from the first strobe becomes rd_data_o[7:4], and bus_d_i[7:4] from the second becomes rd_data_o[3:0].
- R10: done_o pulses for one cycle, in the first cycle with busy_o low, after slots x strobes cycles of busy. req_i is ignored while busy_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode4_i | input | 1 | 1 selects two-nibble transfers, sampled at acceptance |
| req_i | input | 1 | Request a transaction |
| req_rs_i | input | 1 | Register-select value for the transaction |
| req_rd_i | input | 1 | 1 for read, 0 for write |
| req_data_i | input | 8 | Byte to write |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| rd_data_o | output | 8 | Byte returned by the last read |
| bus_rs_o | output | 1 | Bus register-select line |
| bus_rw_o | output | 1 | Bus read/write line (1 = read) |
| bus_en_o | output | 1 | Bus enable strobe |
| bus_d_o | output | 8 | Data driven onto the bus |
| bus_d_oe_o | output | 1 | Data bus output enable |
| bus_d_i | input | 8 | Data read from the bus |

## Verification
All four select/direction combinations are tried in both bus widths. Doing so tells apart a swapped select or direction line, a missing second strobe and a reversed nibble order. Read vectors place different values on the upper and lower halves of the bus and change the bus between strobes. A design that samples the wrong strobe, the wrong half or the wrong cycle therefore returns a different byte. Strobe rise time, width and spacing are measured in cycles against the rounded-up intervals. A request raised mid-transaction checks that a busy engine starts nothing new.

// File: rtl/chrbus_pkg.sv
package chrbus_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = 4;

  function automatic int unsigned cdiv(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/chrbus_seq.sv
module chrbus_seq #(
  parameter int unsigned AS_C   = 2,
  parameter int unsigned PW_C   = 11,
  parameter int unsigned SLOT_C = 25,
  localparam int unsigned TW    = $clog2(SLOT_C + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic two_i,
  output logic active_o,
  output logic en_o,
  output logic nib_o,
  output logic cap_o,
  output logic done_o
);
  logic [TW-1:0] t_q, t_d;
  logic act_q, act_d, nib_q, nib_d, en_q, en_d, done_q, done_d;
  logic last_slot, more;

  assign last_slot = act_q && (t_q == TW'(SLOT_C - 1));
  assign more      = two_i && !nib_q;

  always_comb begin
    t_d   = t_q;
    act_d = act_q;
    nib_d = nib_q;
    if (start_i) begin
      act_d = 1'b1;
      t_d   = '0;
      nib_d = 1'b0;
    end else if (last_slot) begin
      t_d = '0;
      if (more) nib_d = 1'b1;
      else      act_d = 1'b0;
    end else if (act_q) begin
      t_d = t_q + TW'(1);
    end
    en_d   = act_d && (t_d >= TW'(AS_C)) && (t_d < TW'(AS_C + PW_C));
    done_d = last_slot && !more;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q    <= '0;
      act_q  <= 1'b0;
      nib_q  <= 1'b0;
      en_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      t_q    <= t_d;
      act_q  <= act_d;
      nib_q  <= nib_d;
      en_q   <= en_d;
      done_q <= done_d;
    end
  end

  // last high cycle of the strobe: read sample point
  assign cap_o    = act_q && (t_q == TW'(AS_C + PW_C - 1));
  assign active_o = act_q;
  assign en_o     = en_q;
  assign nib_o    = nib_q;
  assign done_o   = done_q;
endmodule

// File: rtl/chrbus_dpath.sv
module chrbus_dpath
  import chrbus_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              four_i,
  input  logic              nib_i,
  input  logic              cap_i,
  input  logic [BYTE_W-1:0] bus_d_i,
  output logic [BYTE_W-1:0] bus_d_o,
  output logic [BYTE_W-1:0] rd_data_o
);
  logic [NIB_W-1:0] hi_w, lo_w, bus_hi;
  logic [BYTE_W-1:0] rd_q;

  assign hi_w   = wdata_i[BYTE_W-1:NIB_W];
  assign lo_w   = wdata_i[NIB_W-1:0];
  assign bus_hi = bus_d_i[BYTE_W-1:NIB_W];

  always_comb begin
    if (!four_i)    bus_d_o = wdata_i;
    else if (nib_i) bus_d_o = {lo_w, {NIB_W{1'b0}}};
    else            bus_d_o = {hi_w, {NIB_W{1'b0}}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
    end else if (cap_i) begin
      if (!four_i)    rd_q <= bus_d_i;
      else if (nib_i) rd_q[NIB_W-1:0] <= bus_hi;
      else            rd_q[BYTE_W-1:NIB_W] <= bus_hi;
    end
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/chrbus_engine.sv
module chrbus_engine
  import chrbus_pkg::*;
#(
  parameter int unsigned CLK_NS         = 20,
  parameter int unsigned CYCLE_NS       = 500,
  parameter int unsigned PULSE_NS       = 220,
  parameter int unsigned ADDR_SETUP_NS  = 40,
  parameter int unsigned ADDR_HOLD_NS   = 10,
  parameter int unsigned WDATA_SETUP_NS = 60,
  parameter int unsigned WDATA_HOLD_NS  = 10,
  parameter int unsigned RDATA_DLY_NS   = 120
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode4_i,
  input  logic              req_i,
  input  logic              req_rs_i,
  input  logic              req_rd_i,
  input  logic [BYTE_W-1:0] req_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              bus_rs_o,
  output logic              bus_rw_o,
  output logic              bus_en_o,
  output logic [BYTE_W-1:0] bus_d_o,
  output logic              bus_d_oe_o,
  input  logic [BYTE_W-1:0] bus_d_i
);
  localparam int unsigned AS_C   = umax(cdiv(ADDR_SETUP_NS, CLK_NS), 1);
  localparam int unsigned PW_C   = umax(umax(cdiv(PULSE_NS, CLK_NS), cdiv(RDATA_DLY_NS, CLK_NS)),
                                        umax(cdiv(WDATA_SETUP_NS, CLK_NS), 1));
  localparam int unsigned HD_C   = umax(umax(cdiv(ADDR_HOLD_NS, CLK_NS), cdiv(WDATA_HOLD_NS, CLK_NS)), 1);
  localparam int unsigned SLOT_C = umax(cdiv(CYCLE_NS, CLK_NS), AS_C + PW_C + HD_C);

  logic              active, nib, cap, accept;
  logic              rs_q, rw_q, four_q;
  logic [BYTE_W-1:0] wdata_q;

  assign accept = req_i && !active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rs_q    <= 1'b0;
      rw_q    <= 1'b0;
      four_q  <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      rs_q    <= req_rs_i;
      rw_q    <= req_rd_i;
      four_q  <= mode4_i;
      wdata_q <= req_data_i;
    end
  end

  chrbus_seq #(
    .AS_C  (AS_C),
    .PW_C  (PW_C),
    .SLOT_C(SLOT_C)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .two_i   (four_q),
    .active_o(active),
    .en_o    (bus_en_o),
    .nib_o   (nib),
    .cap_o   (cap),
    .done_o  (done_o)
  );

  chrbus_dpath u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wdata_i  (wdata_q),
    .four_i   (four_q),
    .nib_i    (nib),
    .cap_i    (cap && rw_q),
    .bus_d_i  (bus_d_i),
    .bus_d_o  (bus_d_o),
    .rd_data_o(rd_data_o)
  );

  assign busy_o     = active;
  assign bus_rs_o   = rs_q;
  assign bus_rw_o   = rw_q;
  assign bus_d_oe_o = active && !rw_q;
endmodule

// File: rtl/chrbus_engine_chk.sv
module chrbus_engine_chk
  import chrbus_pkg::*;
#(
  parameter int unsigned CLK_NS   = 20,
  parameter int unsigned CYCLE_NS = 500,
  parameter int unsigned PULSE_NS = 220
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              bus_rs_o,
  input logic              bus_rw_o,
  input logic              bus_en_o,
  input logic              bus_d_oe_o,
  input logic [BYTE_W-1:0] bus_d_o
);
  localparam int unsigned PW_MIN  = cdiv(PULSE_NS, CLK_NS);
  localparam int unsigned CYC_MIN = cdiv(CYCLE_NS, CLK_NS);

  logic        en_prev, seen_rise;
  logic [15:0] en_len, gap;
  logic        rise;

  assign rise = bus_en_o && !en_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_prev   <= 1'b0;
      seen_rise <= 1'b0;
      en_len    <= '0;
      gap       <= '0;
    end else begin
      en_prev <= bus_en_o;
      en_len  <= bus_en_o ? en_len + 16'd1 : 16'd0;
      if (rise) begin
        seen_rise <= 1'b1;
        gap       <= 16'd1;
      end else if (gap != 16'hFFFF) begin
        gap <= gap + 16'd1;
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !bus_en_o && !bus_d_oe_o); // R1
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_en_o |-> $stable(bus_rs_o) && $stable(bus_rw_o)); // R3
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_en_o && en_prev) |-> $stable(bus_rs_o) && $stable(bus_rw_o)); // R3
  AST_PULSE_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_en_o && en_prev) |-> en_len >= 16'(PW_MIN)); // R4
  AST_CYCLE_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && seen_rise) |-> gap >= 16'(CYC_MIN)); // R5
  AST_WRITE_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !bus_rw_o |-> bus_d_oe_o); // R6
  AST_WDATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_en_o && !bus_rw_o |-> $stable(bus_d_o)); // R6
  AST_READ_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && bus_rw_o |-> !bus_d_oe_o); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_DONE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o)); // R10
endmodule

bind chrbus_engine chrbus_engine_chk #(
  .CLK_NS  (CLK_NS),
  .CYCLE_NS(CYCLE_NS),
  .PULSE_NS(PULSE_NS)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .bus_rs_o  (bus_rs_o),
  .bus_rw_o  (bus_rw_o),
  .bus_en_o  (bus_en_o),
  .bus_d_oe_o(bus_d_oe_o),
  .bus_d_o   (bus_d_o)
);

// File: tb/chrbus_engine_test.sv
`timescale 1ns/1ps
module chrbus_engine_test;
  localparam int T_NS = 20;
  localparam int AS   = (40 + T_NS - 1) / T_NS;
  localparam int PW   = (220 + T_NS - 1) / T_NS;
  localparam int CYC  = (500 + T_NS - 1) / T_NS;
  localparam int SLOT = (CYC > AS + PW + 1) ? CYC : AS + PW + 1;

  // {mode4, rs, rd, wdata, strobe1 bus, strobe2 bus, expected read}
  localparam logic [34:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 8'h38, 8'h00, 8'h00, 8'h00},
    {1'b0, 1'b1, 1'b0, 8'hA5, 8'h00, 8'h00, 8'h00},
    {1'b0, 1'b0, 1'b1, 8'h00, 8'h4F, 8'h00, 8'h4F},
    {1'b0, 1'b1, 1'b1, 8'h00, 8'hC3, 8'h00, 8'hC3},
    {1'b1, 1'b0, 1'b0, 8'h28, 8'h00, 8'h00, 8'h00},
    {1'b1, 1'b1, 1'b0, 8'h5E, 8'h00, 8'h00, 8'h00},
    {1'b1, 1'b1, 1'b1, 8'h00, 8'h70, 8'h9F, 8'h79},
    {1'b1, 1'b0, 1'b1, 8'h00, 8'hB1, 8'h46, 8'hB4}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode4 = 1'b0, req = 1'b0, req_rs = 1'b0, req_rd = 1'b0;
  logic [7:0] req_data = '0, bus_in = '0;
  logic       busy, done, bus_rs, bus_rw, bus_en, bus_oe;
  logic [7:0] rd_data, bus_out;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #(T_NS/2) clk = ~clk;

  chrbus_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .mode4_i(mode4), .req_i(req),
    .req_rs_i(req_rs), .req_rd_i(req_rd), .req_data_i(req_data),
    .busy_o(busy), .done_o(done), .rd_data_o(rd_data),
    .bus_rs_o(bus_rs), .bus_rw_o(bus_rw), .bus_en_o(bus_en),
    .bus_d_o(bus_out), .bus_d_oe_o(bus_oe), .bus_d_i(bus_in)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic run_txn(input logic [34:0] v);
    logic m4, rs, rd;
    logic [7:0] wd, b0, b1, exp_rd, exp_d;
    int strobes, wid, rise_k, done_k;
    bit prev_en, oe_bad;
    logic [7:0] last_d;
    {m4, rs, rd, wd, b0, b1, exp_rd} = v;
    strobes = 0; wid = 0; rise_k = 0; done_k = 0; prev_en = 0; oe_bad = 0; last_d = '0;
    @(negedge clk);
    mode4 = m4; req_rs = rs; req_rd = rd; req_data = wd; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    for (int k = 1; k <= 3 * SLOT; k++) begin
      if (k > 1) @(negedge clk);
      if (bus_en && !prev_en) begin
        strobes = strobes + 1;
        if (strobes == 1) chk(k == AS + 1, "R3", "first rise cycle", k, AS + 1);
        else              chk(k - rise_k == SLOT, "R5", "rise spacing", k - rise_k, SLOT);
        rise_k = k;
        chk(bus_rs == rs, "R2", "rs during strobe", bus_rs, rs);
        chk(bus_rw == rd, "R2", "rw during strobe", bus_rw, rd);
      end
      bus_in = bus_en ? ((strobes <= 1) ? b0 : b1) : 8'h00;
      if (rd && bus_oe) oe_bad = 1;
      if (!rd && busy && !bus_oe) oe_bad = 1;
      if (bus_en) begin
        wid = wid + 1;
        last_d = bus_out;
      end
      if (!bus_en && prev_en) begin
        chk(wid == PW, "R4", "pulse width", wid, PW);
        wid = 0;
        if (!rd) begin
          if (!m4)               exp_d = wd;
          else if (strobes == 1) exp_d = {wd[7:4], 4'h0};
          else                   exp_d = {wd[3:0], 4'h0};
          chk(last_d == exp_d, m4 ? "R7" : "R6", "write data", last_d, exp_d);
        end
      end
      prev_en = bus_en;
      if (done) begin
        done_k = k;
        break;
      end
    end
    bus_in = 8'h00;
    chk(strobes == (m4 ? 2 : 1), m4 ? "R9" : "R8", "strobe count", strobes, m4 ? 2 : 1);
    chk(done_k == strobes * SLOT + 1, "R10", "done cycle", done_k, strobes * SLOT + 1);
    chk(!busy, "R10", "busy after done", busy, 0);
    chk(!oe_bad, rd ? "R8" : "R6", "output enable", oe_bad, 0);
    if (rd) chk(rd_data == exp_rd, m4 ? "R9" : "R8", "read byte", rd_data, exp_rd);
    @(negedge clk);
    chk(!done, "R10", "done one cycle", done, 0);
  endtask

  initial begin
    int strobes, done_k;
    bit prev_en;
    logic [7:0] last_d;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !bus_en && !bus_oe, "R1", "reset outputs",
        {busy, done, bus_en, bus_oe}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !bus_en && !bus_oe, "R1", "idle after reset", {busy, bus_en, bus_oe}, 0);

    for (int i = 0; i < 8; i++) run_txn(VEC[i]);

    // request while busy is ignored
    @(negedge clk);
    mode4 = 1'b0; req_rs = 1'b1; req_rd = 1'b0; req_data = 8'h11; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    strobes = 0; done_k = 0; prev_en = 0; last_d = '0;
    for (int k = 1; k <= 3 * SLOT; k++) begin
      if (k > 1) @(negedge clk);
      if (k == 5) begin
        req_data = 8'hFF; req_rd = 1'b1; req = 1'b1;
      end else begin
        req = 1'b0;
      end
      if (bus_en && !prev_en) strobes = strobes + 1;
      if (bus_en) last_d = bus_out;
      prev_en = bus_en;
      if (done) begin
        done_k = k;
        break;
      end
    end
    req = 1'b0;
    chk(strobes == 1, "R10", "strobes with mid request", strobes, 1);
    chk(done_k == SLOT + 1, "R10", "done with mid request", done_k, SLOT + 1);
    chk(last_d == 8'h11, "R6", "data kept under mid request", last_d, 8'h11);
    chk(bus_rw == 1'b0, "R2", "rw kept under mid request", bus_rw, 0);
    @(negedge clk);
    chk(!busy && !bus_en, "R10", "no second transaction", {busy, bus_en}, 0);
    chk(!bus_oe, "R1", "oe idle", bus_oe, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule